// File: doc/BRIEF.md
# Flash Command Interface with Write Protection

This block is the command and protection front end of a NOR-style flash memory. It watches the chip-select and write strobes of the host bus and decodes a small command set. Every operation that changes the memory is a two-step sequence: a setup byte first, then a confirm or data byte. The operations are word write, block erase, full-chip erase and lock-bit configuration. Before it launches an operation, the block decides whether the target may be touched. That decision follows a fixed priority chain: device reset, programming-supply lockout, the boot-block protect pin, the per-block lock bits, and the permanent lock.

An operation that is granted drops the ready line for a fixed number of clock cycles. At the end it emits a one-cycle completion pulse that carries the operation kind, the address and the data. A change to the lock bits takes effect only at that moment. A refused operation leaves ready high and records the reason in sticky error bits of a status byte. The memory array itself, voltage sensing and real program or erase timing are outside the block. Voltage conditions arrive as comparator flags, and a counter stands in for the operation time.

The address is split into equal blocks, and the block index is the top `BLK_W` bits of the address. The two boot blocks are blocks 0 and 1 by default, or the two highest blocks when `BOOT_AT_TOP` is set.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A bus write is taken once, on the clock edge where ce_n and we_n are first seen low together. If either strobe stays high, nothing is taken and the command state does not move.
- R2: Command bytes are read in read-array state: 0x40 starts a word write (the next write supplies data and address), 0x20 a block erase, 0x30 a chip erase, 0x60 a lock configuration, and 0x50 clears the error bits. A second byte of 0xD0 confirms either erase. After 0x60, the byte 0x01 locks the addressed block, 0xF1 sets the permanent lock and 0xD0 clears all block locks. Any other second byte launches nothing and sets status bits 5 and 4.
- R3: Power-on reset, leaving device reset, and any cycle with vdd_low high return the decoder to read-array state, so a pending setup byte is discarded.
- R4: While rst_n is low, bus writes are ignored and no completion pulse is produced.
- R5: If rst_n goes low while an operation is running, ready stays low until rst_n returns high. The operation is dropped with no completion pulse and no lock change.
- R6: rst_n low, or por_n low, clears status bits 6 to 0. Status bit 7 always equals ready.
- R7: While vpp_low is high, every modifying operation is refused with status bit 3 set plus its category bit. Status bit 1 is not set, even if the target is locked.
- R8: With wp_n low, a word write or block erase to either boot block is refused with status bit 1, whatever the block's lock bit. Other blocks are not affected by wp_n.
- R9: A set lock bit refuses a word write or block erase to that block (status bit 1). A chip erase is refused if any block is locked or if wp_n is low.
- R10: Once perm_lock is set, setting or clearing block locks is refused with status bit 1, and lock_bits no longer change.
- R11: A refused operation leaves ready high and produces no completion pulse. It sets its category bit: bit 5 for erases, bit 4 for writes and lock operations. Error bits stay set until a 0x50 command.
- R12: A granted operation drives ready low for exactly BUSY_CYC cycles after the accepting edge. It then pulses done for one cycle with done_kind (1 word write, 2 block erase, 3 chip erase, 4 lock set, 5 lock clear, 6 permanent lock), done_addr and done_data. Lock changes appear together with that pulse. Writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low; clears everything including locks |
| rst_n | input | 1 | Device reset, synchronous, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Bus address; top BLK_W bits select the block |
| din | input | 8 | Bus write data |
| wp_n | input | 1 | Boot-block write protect, active low |
| vpp_low | input | 1 | Programming supply below lockout |
| vdd_low | input | 1 | Logic supply below lockout |
| ready | output | 1 | High when no operation or abort is pending |
| status | output | 8 | Bit 7 ready, 5 erase error, 4 write error, 3 supply error, 1 protect error |
| lock_bits | output | 2**BLK_W | Per-block lock bits |
| perm_lock | output | 1 | Permanent lock bit |
| done | output | 1 | One-cycle completion pulse |
| done_kind | output | 3 | Kind of the completed operation |
| done_addr | output | ADDR_W | Address of the completed operation |
| done_data | output | 8 | Data byte of the completed operation |

## Verification
Two pairs of functions can act in the same cycle.

The first pair is device reset and the running timer, which compete for the ready line and the completion pulse. The bench asserts reset inside the busy window of an erase and of a lock-set. It then expects ready to stay low with no completion pulse and unchanged lock bits.

The second pair is supply lockout and lock refusal, which meet on the same request when an erase targets a locked block while vpp_low is high. That case must report only the supply bit, never the protect bit.

A behavioural model in the bench is stepped on every edge and compared on every cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      K_NONE   = 3'd0,
      K_WORD   = 3'd1,
      K_BERASE = 3'd2,
      K_CERASE = 3'd3,
      K_LSET   = 3'd4,
      K_LCLR   = 3'd5,
      K_PERM   = 3'd6
   } op_kind_t;

   typedef enum logic [2:0] {
      S_ARRAY,
      S_WORD,
      S_BERASE,
      S_CERASE,
      S_LOCK
   } cmd_state_t;

   localparam logic [7:0] OP_WORD    = 8'h40;
   localparam logic [7:0] OP_BERASE  = 8'h20;
   localparam logic [7:0] OP_CERASE  = 8'h30;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_CLRSTAT = 8'h50;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_LSET    = 8'h01;
   localparam logic [7:0] OP_PERM    = 8'hF1;

   typedef struct packed {
      logic ers;
      logic prg;
      logic vpp;
      logic lck;
   } err_t;

endpackage

// File: rtl/fc_bus_strobe.sv
module fc_bus_strobe (
   input  logic clk,
   input  logic por_n,
   input  logic ce_n,
   input  logic we_n,
   output logic strobe
);
   logic sel_now;
   logic sel_prev;

   assign sel_now = ~ce_n & ~we_n;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) sel_prev <= 1'b0;
      else        sel_prev <= sel_now;
   end

   assign strobe = sel_now & ~sel_prev;

   // R1
   single_take_chk: assert property (@(posedge clk) disable iff (!por_n)
      strobe |=> !strobe);
endmodule

// File: rtl/fc_busy_timer.sv
module fc_busy_timer #(
   parameter int unsigned CYC = 6
) (
   input  logic clk,
   input  logic por_n,
   input  logic clear,
   input  logic load,
   output logic busy,
   output logic last
);
   localparam int unsigned CW = $clog2(CYC + 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("fc_busy_timer: CYC must be at least 1");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)         cnt <= '0;
      else if (clear)     cnt <= '0;
      else if (load)      cnt <= CW'(CYC);
      else if (cnt != '0) cnt <= cnt - CW'(1);
   end

   assign busy = (cnt != '0);
   assign last = (cnt == CW'(1));

   // R12
   load_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
      load |-> !busy);
endmodule

// File: rtl/fc_guard.sv
module fc_guard
   import flash_cmd_pkg::*;
#(
   parameter int unsigned BLK_W       = 3,
   parameter bit          BOOT_AT_TOP = 1'b0,
   localparam int unsigned NBLK       = 1 << BLK_W
) (
   input  op_kind_t         kind,
   input  logic [BLK_W-1:0] blk,
   input  logic [NBLK-1:0]  lock_bits,
   input  logic             perm_lock,
   input  logic             wp_n,
   input  logic             vpp_low,
   output logic             deny,
   output err_t             err
);
   logic [NBLK-1:0] boot_mask;

   if (BOOT_AT_TOP) begin : g_boot_top
      assign boot_mask = {2'b11, {(NBLK-2){1'b0}}};
   end else begin : g_boot_bottom
      assign boot_mask = {{(NBLK-2){1'b0}}, 2'b11};
   end

   logic wp_hit;
   logic lock_hit;
   logic erase_kind;

   assign wp_hit     = ~wp_n & boot_mask[blk];
   assign lock_hit   = lock_bits[blk];
   assign erase_kind = (kind == K_BERASE) || (kind == K_CERASE);

   always_comb begin
      deny = 1'b0;
      err  = '0;
      if (vpp_low) begin
         deny    = (kind != K_NONE);
         err.vpp = (kind != K_NONE);
      end else begin
         unique case (kind)
            K_WORD, K_BERASE: if (wp_hit || lock_hit)     begin deny = 1'b1; err.lck = 1'b1; end
            K_CERASE:         if (!wp_n || |lock_bits)    begin deny = 1'b1; err.lck = 1'b1; end
            K_LSET, K_LCLR:   if (perm_lock)              begin deny = 1'b1; err.lck = 1'b1; end
            default: ;
         endcase
      end
      if (deny) begin
         err.ers = erase_kind;
         err.prg = ~erase_kind;
      end
   end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned BLK_W       = 3,
   parameter int unsigned BUSY_CYC    = 6,
   parameter bit          BOOT_AT_TOP = 1'b0,
   localparam int unsigned NBLK       = 1 << BLK_W
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   input  logic              wp_n,
   input  logic              vpp_low,
   input  logic              vdd_low,
   output logic              ready,
   output logic [7:0]        status,
   output logic [NBLK-1:0]   lock_bits,
   output logic              perm_lock,
   output logic              done,
   output logic [2:0]        done_kind,
   output logic [ADDR_W-1:0] done_addr,
   output logic [7:0]        done_data
);
   if (BLK_W < 2 || ADDR_W <= BLK_W) begin : g_bad_geom
      $error("flash_cmd_ctrl: need BLK_W >= 2 and ADDR_W > BLK_W");
   end

   logic             strobe;
   logic             busy;
   logic             last;
   logic             acc;
   logic             launch;
   logic             refuse;
   logic             g_deny;
   err_t             g_err;
   cmd_state_t       state;
   cmd_state_t       nxt_state;
   op_kind_t         req_kind;
   logic             seq_err;
   logic             clr_stat;
   err_t             err;
   logic             abort_q;
   logic [NBLK-1:0]  lock_q;
   logic             perm_q;
   logic             done_q;
   op_kind_t         done_kind_q;
   logic [ADDR_W-1:0] done_addr_q;
   logic [7:0]       done_data_q;
   op_kind_t         run_kind;
   logic [ADDR_W-1:0] run_addr;
   logic [7:0]       run_data;
   logic [BLK_W-1:0] req_blk;
   logic [BLK_W-1:0] run_blk;

   assign req_blk = addr[ADDR_W-1 -: BLK_W];
   assign run_blk = run_addr[ADDR_W-1 -: BLK_W];

   fc_bus_strobe i_strobe (
      .clk    (clk),
      .por_n  (por_n),
      .ce_n   (ce_n),
      .we_n   (we_n),
      .strobe (strobe)
   );

   fc_busy_timer #(.CYC(BUSY_CYC)) i_timer (
      .clk   (clk),
      .por_n (por_n),
      .clear (~rst_n),
      .load  (launch),
      .busy  (busy),
      .last  (last)
   );

   fc_guard #(.BLK_W(BLK_W), .BOOT_AT_TOP(BOOT_AT_TOP)) i_guard (
      .kind      (req_kind),
      .blk       (req_blk),
      .lock_bits (lock_q),
      .perm_lock (perm_q),
      .wp_n      (wp_n),
      .vpp_low   (vpp_low),
      .deny      (g_deny),
      .err       (g_err)
   );

   assign acc = strobe & rst_n & ~busy & ~vdd_low;

   always_comb begin
      nxt_state = state;
      req_kind  = K_NONE;
      seq_err   = 1'b0;
      clr_stat  = 1'b0;
      unique case (state)
         S_ARRAY: begin
            unique case (din)
               OP_WORD:    nxt_state = S_WORD;
               OP_BERASE:  nxt_state = S_BERASE;
               OP_CERASE:  nxt_state = S_CERASE;
               OP_LOCK:    nxt_state = S_LOCK;
               OP_CLRSTAT: clr_stat  = 1'b1;
               default: ;
            endcase
         end
         S_WORD: begin
            nxt_state = S_ARRAY;
            req_kind  = K_WORD;
         end
         S_BERASE: begin
            nxt_state = S_ARRAY;
            if (din == OP_CONFIRM) req_kind = K_BERASE;
            else                   seq_err  = 1'b1;
         end
         S_CERASE: begin
            nxt_state = S_ARRAY;
            if (din == OP_CONFIRM) req_kind = K_CERASE;
            else                   seq_err  = 1'b1;
         end
         S_LOCK: begin
            nxt_state = S_ARRAY;
            unique case (din)
               OP_LSET:    req_kind = K_LSET;
               OP_PERM:    req_kind = K_PERM;
               OP_CONFIRM: req_kind = K_LCLR;
               default:    seq_err  = 1'b1;
            endcase
         end
         default: nxt_state = S_ARRAY;
      endcase
   end

   assign refuse = acc & (req_kind != K_NONE) & g_deny;
   assign launch = acc & (req_kind != K_NONE) & ~g_deny;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         state       <= S_ARRAY;
         err         <= '0;
         abort_q     <= 1'b0;
         lock_q      <= '0;
         perm_q      <= 1'b0;
         done_q      <= 1'b0;
         done_kind_q <= K_NONE;
         done_addr_q <= '0;
         done_data_q <= '0;
         run_kind    <= K_NONE;
         run_addr    <= '0;
         run_data    <= '0;
      end else if (!rst_n) begin
         state   <= S_ARRAY;
         err     <= '0;
         abort_q <= abort_q | busy;
         done_q  <= 1'b0;
      end else begin
         abort_q <= 1'b0;
         done_q  <= last;
         if (last) begin
            done_kind_q <= run_kind;
            done_addr_q <= run_addr;
            done_data_q <= run_data;
            unique case (run_kind)
               K_LSET:  lock_q[run_blk] <= 1'b1;
               K_LCLR:  lock_q          <= '0;
               K_PERM:  perm_q          <= 1'b1;
               default: ;
            endcase
         end
         if (vdd_low) begin
            state <= S_ARRAY;
         end else if (acc) begin
            state <= nxt_state;
            if (clr_stat)     err <= '0;
            else if (seq_err) begin
               err.ers <= 1'b1;
               err.prg <= 1'b1;
            end else if (refuse) err <= err_t'(err | g_err);
            if (launch) begin
               run_kind <= req_kind;
               run_addr <= addr;
               run_data <= din;
            end
         end
      end
   end

   assign ready     = ~busy & ~abort_q;
   assign status    = {ready, 1'b0, err.ers, err.prg, err.vpp, 1'b0, err.lck, 1'b0};
   assign lock_bits = lock_q;
   assign perm_lock = perm_q;
   assign done      = done_q;
   assign done_kind = done_kind_q;
   assign done_addr = done_addr_q;
   assign done_data = done_data_q;

   // R12
   done_ready_chk: assert property (@(posedge clk) disable iff (!por_n)
      done |-> ready);
   // R6
   rst_status_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> (status[6:0] == 7'd0));
   // R4
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
      !rst_n |=> !done);
   // R5
   abort_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n && !ready) |=> !ready);
   // R10
   perm_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
      perm_lock |=> $stable(lock_bits));
   // R7
   vpp_block_chk: assert property (@(posedge clk) disable iff (!por_n)
      (acc && vpp_low && req_kind != K_NONE) |=> (ready && status[3] && !status[1]));
   // R11
   refuse_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
      refuse |=> (ready && !done && status[5:4] != 2'b00));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
   localparam int BUSY = 6;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b1;
   logic        ce_n = 1'b1;
   logic        we_n = 1'b1;
   logic [11:0] addr = '0;
   logic [7:0]  din = '0;
   logic        wp_n = 1'b1;
   logic        vpp_low = 1'b0;
   logic        vdd_low = 1'b0;
   logic        ready;
   logic [7:0]  status;
   logic [7:0]  lock_bits;
   logic        perm_lock;
   logic        done;
   logic [2:0]  done_kind;
   logic [11:0] done_addr;
   logic [7:0]  done_data;

   always #4 clk = ~clk;

   flash_cmd_ctrl #(.ADDR_W(12), .BLK_W(3), .BUSY_CYC(BUSY)) i_flash_cmd_ctrl (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
      .addr(addr), .din(din), .wp_n(wp_n), .vpp_low(vpp_low), .vdd_low(vdd_low),
      .ready(ready), .status(status), .lock_bits(lock_bits), .perm_lock(perm_lock),
      .done(done), .done_kind(done_kind), .done_addr(done_addr), .done_data(done_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   int done_cnt = 0;
   bit finished = 0;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   int       m_cnt = 0;
   bit       m_abort = 0, m_prev = 0, m_done = 0;
   int       m_state = 0;
   bit       e_ers = 0, e_prg = 0, e_vpp = 0, e_lck = 0;
   bit [7:0] m_lock = 0;
   bit       m_perm = 0;
   int       m_rk = 0, m_dk = 0;
   bit [11:0] m_ra = 0, m_da = 0;
   bit [7:0]  m_rd = 0, m_dd = 0;
   bit       m_live = 0;

   always @(posedge clk or negedge por_n) begin
      bit wr, busy_old, fire, refused;
      int kind, blk;
      wr = !ce_n && !we_n;
      if (!por_n) begin
         m_cnt = 0; m_abort = 0; m_done = 0; m_state = 0;
         e_ers = 0; e_prg = 0; e_vpp = 0; e_lck = 0;
         m_lock = 0; m_perm = 0; m_rk = 0; m_dk = 0;
         m_ra = 0; m_da = 0; m_rd = 0; m_dd = 0;
         m_prev = 0;
      end else begin
         busy_old = (m_cnt != 0);
         fire = (m_cnt == 1);
         m_done = 0;
         if (!rst_n) begin
            if (busy_old) m_abort = 1;
            m_cnt = 0; m_state = 0;
            e_ers = 0; e_prg = 0; e_vpp = 0; e_lck = 0;
         end else begin
            m_abort = 0;
            if (fire) begin
               m_done = 1; m_dk = m_rk; m_da = m_ra; m_dd = m_rd;
               if (m_rk == 4) m_lock[m_ra[11:9]] = 1;
               if (m_rk == 5) m_lock = 0;
               if (m_rk == 6) m_perm = 1;
            end
            if (m_cnt > 0) m_cnt--;
            if (vdd_low) m_state = 0;
            else if (wr && !m_prev && !busy_old) begin
               kind = 0;
               blk = int'(addr[11:9]);
               if (m_state == 0) begin
                  if (din == 8'h40) m_state = 1;
                  else if (din == 8'h20) m_state = 2;
                  else if (din == 8'h30) m_state = 3;
                  else if (din == 8'h60) m_state = 4;
                  else if (din == 8'h50) begin e_ers = 0; e_prg = 0; e_vpp = 0; e_lck = 0; end
               end else begin
                  if (m_state == 1) kind = 1;
                  else if (m_state == 2 || m_state == 3) begin
                     if (din == 8'hD0) kind = m_state;
                     else begin e_ers = 1; e_prg = 1; end
                  end else begin
                     if (din == 8'h01) kind = 4;
                     else if (din == 8'hF1) kind = 6;
                     else if (din == 8'hD0) kind = 5;
                     else begin e_ers = 1; e_prg = 1; end
                  end
                  m_state = 0;
               end
               if (kind != 0) begin
                  refused = 0;
                  if (vpp_low) begin refused = 1; e_vpp = 1; end
                  else if ((kind == 1 || kind == 2) && ((!wp_n && blk < 2) || m_lock[blk])) begin refused = 1; e_lck = 1; end
                  else if (kind == 3 && (!wp_n || m_lock != 0)) begin refused = 1; e_lck = 1; end
                  else if ((kind == 4 || kind == 5) && m_perm) begin refused = 1; e_lck = 1; end
                  if (refused) begin
                     if (kind == 2 || kind == 3) e_ers = 1; else e_prg = 1;
                  end else begin
                     m_cnt = BUSY; m_rk = kind; m_ra = addr; m_rd = din;
                  end
               end
            end
         end
         m_prev = wr;
      end
   end

   function automatic int m_status();
      bit rdy;
      rdy = (m_cnt == 0) && !m_abort;
      return int'({rdy, 1'b0, e_ers, e_prg, e_vpp, 1'b0, e_lck, 1'b0});
   endfunction

   always @(negedge clk) begin
      if (done) done_cnt++;
      if (m_live && por_n) begin
         chk("R12 ready vs model", int'(ready), int'((m_cnt == 0) && !m_abort));
         chk("R11 status vs model", int'(status), m_status());
         chk("R9 lock_bits vs model", int'(lock_bits), int'(m_lock));
         chk("R10 perm_lock vs model", int'(perm_lock), int'(m_perm));
         chk("R12 done vs model", int'(done), int'(m_done));
         if (m_done) begin
            chk("R12 done_kind vs model", int'(done_kind), m_dk);
            chk("R12 done_addr vs model", int'(done_addr), int'(m_da));
            chk("R12 done_data vs model", int'(done_data), int'(m_dd));
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [11:0] ba(input int b);
      return 12'(b << 9) | 12'h015;
   endfunction

   task automatic bus_write(input int b, input logic [7:0] d);
      @(negedge clk);
      addr = ba(b); din = d; ce_n = 0; we_n = 0;
      @(negedge clk);
      ce_n = 1; we_n = 1;
   endtask

   task automatic half_strobe(input bit ce_low, input logic [7:0] d);
      @(negedge clk);
      din = d; ce_n = !ce_low; we_n = ce_low;
      @(negedge clk);
      ce_n = 1; we_n = 1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      idle(3);
      por_n = 1;
      idle(2);
      m_live = 1;
      // R6 R3: reset state
      chk("R6 status after power-on", int'(status), 8'h80);
      chk("R3 locks after power-on", int'(lock_bits), 0);

      // R12 granted word write
      bus_write(3, 8'h40); bus_write(3, 8'h55);
      chk("R12 ready low after confirm", int'(ready), 0);
      idle(BUSY + 2);
      chk("R12 completion count", done_cnt, 1);
      chk("R12 ready back high", int'(status), 8'h80);

      // R2 bad confirm
      bus_write(2, 8'h20); bus_write(2, 8'hAA); idle(3);
      chk("R2 sequence error bits", int'(status), 8'hB0);
      bus_write(2, 8'h50); idle(2);
      chk("R11 clear status", int'(status), 8'h80);

      // R1 half strobes ignored
      half_strobe(1, 8'h20); bus_write(2, 8'hD0); idle(3);
      half_strobe(0, 8'h20); bus_write(2, 8'hD0); idle(BUSY + 2);
      chk("R1 single strobe has no effect", done_cnt, 1);
      chk("R1 status unchanged", int'(status), 8'h80);

      // R8 boot protect
      wp_n = 0;
      bus_write(0, 8'h40); bus_write(0, 8'h12); idle(3);
      chk("R8 boot block refused", int'(status), 8'h92);
      chk("R11 refused leaves no completion", done_cnt, 1);
      bus_write(0, 8'h50);
      bus_write(5, 8'h20); bus_write(5, 8'hD0); idle(BUSY + 2);
      chk("R8 non-boot block allowed", done_cnt, 2);
      bus_write(5, 8'h30); bus_write(5, 8'hD0); idle(3);
      chk("R9 chip erase refused with wp low", int'(status), 8'hA2);
      bus_write(5, 8'h50);
      wp_n = 1;

      // R9 block lock
      bus_write(4, 8'h60); bus_write(4, 8'h01);
      idle(2);
      chk("R12 lock not applied before completion", int'(lock_bits), 0);
      idle(BUSY);
      chk("R12 lock applied", int'(lock_bits), 8'h10);
      bus_write(4, 8'h20); bus_write(4, 8'hD0); idle(3);
      chk("R9 erase locked block refused", int'(status), 8'hA2);
      bus_write(4, 8'h50);
      bus_write(4, 8'h40); bus_write(4, 8'h77); idle(3);
      chk("R9 write locked block refused", int'(status), 8'h92);
      bus_write(4, 8'h50);
      bus_write(6, 8'h40); bus_write(6, 8'h66); idle(BUSY + 2);
      chk("R9 unlocked block allowed", done_cnt, 4);

      // R7 supply lockout, priority over lock
      vpp_low = 1;
      bus_write(6, 8'h40); bus_write(6, 8'h01); idle(3);
      chk("R7 write refused on vpp", int'(status), 8'h98);
      bus_write(4, 8'h20); bus_write(4, 8'hD0); idle(3);
      chk("R7 vpp outranks lock", int'(status), 8'hB8);
      vpp_low = 0;
      bus_write(4, 8'h50);

      // R11 sticky
      bus_write(4, 8'h40); bus_write(4, 8'h11); idle(2);
      bus_write(6, 8'h40); bus_write(6, 8'h22); idle(BUSY + 2);
      chk("R11 error survives later success", int'(status), 8'h92);
      chk("R11 later op ran", done_cnt, 5);
      bus_write(6, 8'h50);

      // R3 vdd lockout discards setup
      bus_write(6, 8'h20);
      @(negedge clk); vdd_low = 1; @(negedge clk); vdd_low = 0;
      bus_write(6, 8'hD0); idle(BUSY + 2);
      chk("R3 vdd low drops setup", done_cnt, 5);

      // R5 R6 reset during busy erase
      bus_write(6, 8'h20); bus_write(6, 8'hD0);
      rst_n = 0; idle(3);
      chk("R5 ready held low in reset", int'(ready), 0);
      chk("R6 status cleared in reset", int'(status), 8'h00);
      rst_n = 1; idle(2);
      chk("R5 ready after reset", int'(ready), 1);
      idle(BUSY + 2);
      chk("R5 aborted op no completion", done_cnt, 5);

      // R6 error cleared by reset
      bus_write(4, 8'h40); bus_write(4, 8'h11); idle(2);
      rst_n = 0; idle(2); rst_n = 1; idle(2);
      chk("R6 reset clears error", int'(status), 8'h80);

      // R5 reset aborts lock set
      bus_write(2, 8'h60); bus_write(2, 8'h01);
      rst_n = 0; idle(2); rst_n = 1; idle(BUSY + 2);
      chk("R5 aborted lock not applied", int'(lock_bits), 8'h10);

      // R4 writes ignored in reset
      rst_n = 0;
      bus_write(1, 8'h60);
      rst_n = 1;
      bus_write(1, 8'h01); idle(BUSY + 2);
      chk("R4 write during reset ignored", int'(lock_bits), 8'h10);

      // R3 reset drops setup
      bus_write(1, 8'h60);
      rst_n = 0; idle(1); rst_n = 1;
      bus_write(1, 8'h01); idle(BUSY + 2);
      chk("R3 reset drops setup", int'(lock_bits), 8'h10);
      chk("R4 no completions", done_cnt, 5);

      // R10 permanent lock
      bus_write(0, 8'h60); bus_write(0, 8'hF1); idle(BUSY + 2);
      chk("R10 perm set", int'(perm_lock), 1);
      bus_write(3, 8'h60); bus_write(3, 8'h01); idle(3);
      chk("R10 lock set refused", int'(status), 8'h92);
      bus_write(3, 8'h50);
      bus_write(3, 8'h60); bus_write(3, 8'hD0); idle(3);
      chk("R10 lock clear refused", int'(status), 8'h92);
      chk("R10 locks unchanged", int'(lock_bits), 8'h10);

      // R6 R3 power-off clears everything
      @(negedge clk); por_n = 0; idle(2); por_n = 1; idle(2);
      chk("R6 por clears status", int'(status), 8'h80);
      chk("R3 por clears locks", int'(lock_bits) | (int'(perm_lock) << 8), 0);

      idle(4);
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule